// File: doc/BRIEF.md
# Interleaved Two-Channel Pulse Burst Generator

This block drives two switch-control lines that must never be on together. One up-counter advances on a tick strobe, normally 1 MHz, and counts from zero to the active period value before wrapping. The period alternates at every wrap between a short ramp (ramp A) and a long ramp (ramp B). Channel A may pulse only in ramp A and channel B only in ramp B, so the two pulses are interleaved in time with a guaranteed low gap between them.

A one-cycle start strobe requests a burst. The burst always begins at the start of a ramp A. It produces two pulses per channel in the order A, B, A, B, and then both lines return to idle. Period and width values come in on configuration inputs. They are sampled only at a wrap, for the ramp that begins there, so a running ramp is never altered. In normal use a burst is requested about once per second, and both lines stay low between bursts.

Top module: `ilv_burst_gen`

## Requirements
- R1: On each `tick_en` cycle the counter steps by one. Ramp A lasts per_a+1 ticks and ramp B lasts per_b+1 ticks. `ramp_b` reads 0 during ramp A and 1 during ramp B, and it changes only at a wrap.
- R2: Reset is synchronous and active high. It clears the counter, selects ramp A, drives `ch_a`, `ch_b`, `busy` and `done` low, and loads the defaults period 119 and width 59 for the first ramp A. Ramp A after reset therefore lasts 120 ticks.
- R3: During an armed ramp, the owning channel is high from the first tick of the ramp for width+1 ticks. For example, width 59 gives 60 ticks and width 599 gives 600 ticks. The owning channel is `ch_a` in ramp A and `ch_b` in ramp B. A pulse always rises at the start of a ramp.
- R4: `ch_a` and `ch_b` are never high in the same cycle. The low gap from a channel A fall to the following channel B rise is per_a-wid_a ticks. The gap from a B fall to the next A rise is per_b-wid_b ticks.
- R5: A burst is exactly four pulses in the order A, B, A, B. After the burst both lines stay low.
- R6: An accepted trigger arms the first ramp A that begins after it. A trigger that arrives in ramp B waits for the next ramp A, and the first A pulse rises on that ramp's first tick.
- R7: The configuration inputs are sampled only at a wrap, for the ramp that starts there. A change made during a ramp does not change that ramp's length.
- R8: `start` is ignored while `busy` is high. It adds no pulses and does not extend the burst.
- R9: `busy` is high from the cycle after an accepted trigger until the wrap that ends the final ramp B. At that wrap `done` is high for exactly one cycle, with `busy` low.
- R10: While `tick_en` is low the counter, the ramp index and both outputs hold. Pulse widths and gaps in clock cycles scale with the tick spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance strobe (1 µs tick) |
| start | input | 1 | Burst request strobe |
| cfg_per_a | input | CNT_W | Ramp A period (length minus one) |
| cfg_wid_a | input | CNT_W | Channel A width (length minus one) |
| cfg_per_b | input | CNT_W | Ramp B period (length minus one) |
| cfg_wid_b | input | CNT_W | Channel B width (length minus one) |
| ch_a | output | 1 | Channel A switch drive |
| ch_b | output | 1 | Channel B switch drive |
| ramp_b | output | 1 | Ramp index, 1 = ramp B |
| busy | output | 1 | Burst pending or running |
| done | output | 1 | One-cycle end-of-burst pulse |

## Verification
The properties assume the following about the inputs: `start` is a single-cycle strobe, each width value is below its period, and the configuration stays steady while a burst runs. Only under these conditions do the gap and idle-low relations hold. The stimulus changes configuration only while `busy` is low. After a change it waits a full A and B pair before the next request, so both buffered values have been refreshed. It drives every input on the falling clock edge. Extra strobes are sent mid-burst only to exercise the rule that a trigger is ignored while busy.

// File: rtl/ilv_burst_pkg.sv
package ilv_burst_pkg;

  // a channel is high while the ramp count has not passed its width
  function automatic logic pulse_active(input logic [31:0] cnt, input logic [31:0] wid);
    return cnt <= wid;
  endfunction

  // end of ramp: count reached (or passed) the active period
  function automatic logic ramp_end(input logic [31:0] cnt, input logic [31:0] per);
    return cnt >= per;
  endfunction

  // number of ramps per burst for a given pulse count per channel
  function automatic int unsigned burst_ramps(input int unsigned pulses_per_ch);
    return 2 * pulses_per_ch;
  endfunction

endpackage

// File: rtl/ilv_ramp_timer.sv
module ilv_ramp_timer
  import ilv_burst_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned DEF_PER_A = 119,
  parameter int unsigned DEF_WID_A = 59
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] cfg_per_a,
  input  logic [CNT_W-1:0] cfg_wid_a,
  input  logic [CNT_W-1:0] cfg_per_b,
  input  logic [CNT_W-1:0] cfg_wid_b,
  output logic [CNT_W-1:0] cnt,
  output logic             ramp_b,
  output logic [CNT_W-1:0] wid_act,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_q, per_q, wid_q;
  logic             ramp_q;

  assign wrap = tick_en && ramp_end(32'(cnt_q), 32'(per_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      ramp_q <= 1'b0;
      per_q  <= CNT_W'(DEF_PER_A);
      wid_q  <= CNT_W'(DEF_WID_A);
    end else if (wrap) begin
      cnt_q  <= '0;
      ramp_q <= ~ramp_q;
      // buffered values take effect only for the ramp that starts now
      per_q  <= ramp_q ? cfg_per_a : cfg_per_b;
      wid_q  <= ramp_q ? cfg_wid_a : cfg_wid_b;
    end else if (tick_en) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign cnt     = cnt_q;
  assign ramp_b  = ramp_q;
  assign wid_act = wid_q;

endmodule

// File: rtl/ilv_burst_seq.sv
module ilv_burst_seq
  import ilv_burst_pkg::*;
#(
  parameter int unsigned PULSES_PER_CH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic wrap,
  input  logic ramp_b,
  output logic arm,
  output logic busy,
  output logic done,
  output logic accept
);

  localparam int unsigned RAMPS = burst_ramps(PULSES_PER_CH);
  localparam int unsigned RW    = (RAMPS > 2) ? $clog2(RAMPS) : 1;

  logic          pend_q, run_q, arm_q, done_q;
  logic [RW-1:0] rem_q;

  assign accept = start && !pend_q && !run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      run_q  <= 1'b0;
      arm_q  <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) pend_q <= 1'b1;
      if (wrap) begin
        if (pend_q && ramp_b) begin
          // next ramp is A: open the burst
          pend_q <= 1'b0;
          run_q  <= 1'b1;
          arm_q  <= 1'b1;
          rem_q  <= RW'(RAMPS - 1);
        end else if (run_q && rem_q != '0) begin
          arm_q  <= 1'b1;
          rem_q  <= rem_q - 1'b1;
        end else if (run_q) begin
          run_q  <= 1'b0;
          arm_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          arm_q  <= 1'b0;
        end
      end
    end
  end

  assign arm  = arm_q;
  assign busy = pend_q || run_q;
  assign done = done_q;

endmodule

// File: rtl/ilv_pulse_decode.sv
module ilv_pulse_decode
  import ilv_burst_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             arm,
  input  logic             ramp_b,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] wid_act,
  output logic [1:0]       lines
);

  logic in_width;
  assign in_width = pulse_active(32'(cnt), 32'(wid_act));

  // line g owns the ramp whose index equals g
  for (genvar g = 0; g < 2; g++) begin : g_line
    assign lines[g] = arm && (ramp_b == 1'(g)) && in_width;
  end

endmodule

// File: rtl/ilv_burst_gen.sv
module ilv_burst_gen #(
  parameter int unsigned CNT_W         = 16,
  parameter int unsigned DEF_PER_A     = 119,
  parameter int unsigned DEF_WID_A     = 59,
  parameter int unsigned PULSES_PER_CH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             start,
  input  logic [CNT_W-1:0] cfg_per_a,
  input  logic [CNT_W-1:0] cfg_wid_a,
  input  logic [CNT_W-1:0] cfg_per_b,
  input  logic [CNT_W-1:0] cfg_wid_b,
  output logic             ch_a,
  output logic             ch_b,
  output logic             ramp_b,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0] cnt_w, wid_w;
  logic             ovf_evt, accept_evt, arm_w;
  logic [1:0]       lines_w;

  ilv_ramp_timer #(
    .CNT_W(CNT_W), .DEF_PER_A(DEF_PER_A), .DEF_WID_A(DEF_WID_A)
  ) u_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .cfg_per_a(cfg_per_a), .cfg_wid_a(cfg_wid_a),
    .cfg_per_b(cfg_per_b), .cfg_wid_b(cfg_wid_b),
    .cnt(cnt_w), .ramp_b(ramp_b), .wid_act(wid_w), .wrap(ovf_evt)
  );

  ilv_burst_seq #(.PULSES_PER_CH(PULSES_PER_CH)) u_seq (
    .clk(clk), .rst(rst), .start(start), .wrap(ovf_evt), .ramp_b(ramp_b),
    .arm(arm_w), .busy(busy), .done(done), .accept(accept_evt)
  );

  ilv_pulse_decode #(.CNT_W(CNT_W)) u_dec (
    .arm(arm_w), .ramp_b(ramp_b), .cnt(cnt_w), .wid_act(wid_w), .lines(lines_w)
  );

  assign ch_a = lines_w[0];
  assign ch_b = lines_w[1];

endmodule

// File: rtl/ilv_burst_gen_chk.sv
module ilv_burst_gen_chk (
  input logic clk,
  input logic rst,
  input logic tick_en,
  input logic start,
  input logic ch_a,
  input logic ch_b,
  input logic ramp_b,
  input logic busy,
  input logic done,
  input logic ovf_evt,
  input logic accept_evt
);

  assert_excl_R4: assert property (@(posedge clk) disable iff (rst) !(ch_a && ch_b));

  assert_a_owns_ramp_R3: assert property (@(posedge clk) disable iff (rst) ch_a |-> !ramp_b);

  assert_b_owns_ramp_R3: assert property (@(posedge clk) disable iff (rst) ch_b |-> ramp_b);

  assert_ramp_toggle_R1: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> (ramp_b != $past(ramp_b)));

  assert_tick_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(ramp_b));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst) done |-> !busy);

  assert_idle_low_R5: assert property (@(posedge clk) disable iff (rst) !busy |-> (!ch_a && !ch_b));

  assert_busy_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(accept_evt && start));

endmodule

bind ilv_burst_gen ilv_burst_gen_chk u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .start(start),
  .ch_a(ch_a), .ch_b(ch_b), .ramp_b(ramp_b), .busy(busy), .done(done),
  .ovf_evt(ovf_evt), .accept_evt(accept_evt)
);

// File: tb/ilv_burst_gen_bench.sv
module ilv_burst_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  typedef struct {int ch; int width; int gap;} item_t;

  logic clk = 0, rst = 1, tick_en = 1, start = 0;
  logic [W-1:0] cfg_per_a, cfg_wid_a, cfg_per_b, cfg_wid_b;
  logic ch_a, ch_b, ramp_b, busy, done;

  int n_chk = 0, n_fail = 0;
  int tick_div = 1, phase = 0;
  item_t expq[$];

  ilv_burst_gen u_ilv_burst_gen (
    .clk(clk), .rst(rst), .tick_en(tick_en), .start(start),
    .cfg_per_a(cfg_per_a), .cfg_wid_a(cfg_wid_a),
    .cfg_per_b(cfg_per_b), .cfg_wid_b(cfg_wid_b),
    .ch_a(ch_a), .ch_b(ch_b), .ramp_b(ramp_b), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // tick strobe generator
  always @(negedge clk) begin
    phase = (phase + 1 >= tick_div) ? 0 : phase + 1;
    tick_en = (phase == 0);
  end

  // monitor: measures pulses at the ports and compares with the queue
  logic prev[2];
  logic prev_ramp;
  int   len[2];
  int   gap_at_rise[2];
  int   since_fall = -1;
  always @(negedge clk) begin
    logic cur[2];
    cur[0] = ch_a; cur[1] = ch_b;
    if (rst) begin
      prev[0] = 0; prev[1] = 0; prev_ramp = 0; since_fall = -1;
    end else begin
      if (ch_a && ch_b) chk(0, "R4 both lines high", 2, 1);
      for (int c = 0; c < 2; c++) begin
        if (cur[c] && !prev[c]) begin
          gap_at_rise[c] = since_fall;
          len[c] = 0;
          chk(prev_ramp != ramp_b, "R3 pulse rise at ramp start", 32'(ramp_b), 32'(!prev_ramp));
        end
        if (cur[c]) len[c]++;
        if (!cur[c] && prev[c]) begin
          if (expq.size() == 0) begin
            chk(0, "R8 unexpected pulse", c, -1);
          end else begin
            item_t it;
            it = expq.pop_front();
            chk(it.ch == c, "R5 pulse order", c, it.ch);
            chk(it.width == len[c], "R3 pulse width", len[c], it.width);
            if (it.gap >= 0) chk(it.gap == gap_at_rise[c], "R4 gap", gap_at_rise[c], it.gap);
          end
          since_fall = 0;
        end
      end
      if (!ch_a && !ch_b && since_fall >= 0) since_fall++;
      prev[0] = cur[0]; prev[1] = cur[1]; prev_ramp = ramp_b;
    end
  end

  task automatic pulse_start();
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_a_start();
    logic p;
    p = ramp_b;
    forever begin
      @(negedge clk);
      if (p && !ramp_b) break;
      p = ramp_b;
    end
  endtask

  // mode 0: start now, 1: start inside ramp B, 2: extra start mid-burst
  task automatic run_burst(input int pa, input int wa, input int pb, input int wb, input int mode);
    item_t it;
    int guard;
    if (mode == 1) begin
      while (!ramp_b) @(negedge clk);
      repeat (3) @(negedge clk);
    end
    for (int k = 0; k < 2; k++) begin
      it.ch = 0; it.width = (wa + 1) * tick_div; it.gap = (k == 0) ? -1 : (pb - wb) * tick_div;
      expq.push_back(it);
      it.ch = 1; it.width = (wb + 1) * tick_div; it.gap = (pa - wa) * tick_div;
      expq.push_back(it);
    end
    pulse_start();
    chk(busy == 1, "R9 busy after trigger", 32'(busy), 1);
    if (mode == 1) begin
      wait_a_start();
      chk(ch_a == 1, "R6 first A at next ramp A start", 32'(ch_a), 1);
    end
    if (mode == 2) begin
      while (!ch_a) @(negedge clk);
      pulse_start();
      chk(busy == 1, "R8 busy held across ignored trigger", 32'(busy), 1);
    end
    guard = 0;
    while (!done && guard < 100000) begin @(negedge clk); guard++; end
    chk(done == 1, "R9 done seen", 32'(done), 1);
    chk(busy == 0, "R9 busy low at done", 32'(busy), 0);
    chk(expq.size() == 0, "R5 four pulses delivered", expq.size(), 0);
    @(negedge clk);
    chk(done == 0, "R9 done single cycle", 32'(done), 0);
    repeat ((pa + pb + 2) * tick_div * 2) @(negedge clk);
    chk(!ch_a && !ch_b, "R5 idle low after burst", 32'({ch_a, ch_b}), 0);
    chk(busy == 0, "R8 no burst restarted", 32'(busy), 0);
  endtask

  task automatic set_cfg(input int pa, input int wa, input int pb, input int wb);
    cfg_per_a = W'(pa); cfg_wid_a = W'(wa); cfg_per_b = W'(pb); cfg_wid_b = W'(wb);
    wait_a_start();
    wait_a_start();
  endtask

  initial begin
    int cnt;
    cfg_per_a = 19; cfg_wid_a = 9; cfg_per_b = 49; cfg_wid_b = 29;
    repeat (4) @(negedge clk);
    chk(!ch_a && !ch_b && !busy && !done && !ramp_b, "R2 reset state", 32'({ch_a, ch_b, busy, done, ramp_b}), 0);
    rst = 0;
    // R2: first ramp A uses the default period 119
    cnt = 1;
    forever begin @(negedge clk); if (ramp_b) break; cnt++; end
    chk(cnt == 120, "R2 default first ramp A", cnt, 120);
    cnt = 1;
    forever begin @(negedge clk); if (!ramp_b) break; cnt++; end
    chk(cnt == 50, "R1 ramp B length", cnt, 50);

    // R7: change period mid ramp A
    wait_a_start();
    cnt = 1;
    forever begin
      @(negedge clk);
      if (ramp_b) break;
      cnt++;
      if (cnt == 5) cfg_per_a = 29;
    end
    chk(cnt == 20, "R7 running ramp kept its length", cnt, 20);
    wait_a_start();
    cnt = 1;
    forever begin @(negedge clk); if (ramp_b) break; cnt++; end
    chk(cnt == 30, "R7 new period on next ramp", cnt, 30);
    set_cfg(19, 9, 49, 29);

    run_burst(19, 9, 49, 29, 0);                // R5 basic burst
    run_burst(19, 9, 49, 29, 1);                // R6 trigger in ramp B
    run_burst(19, 9, 49, 29, 2);                // R8 trigger while busy
    set_cfg(23, 4, 40, 39);
    run_burst(23, 4, 40, 39, 0);                // R4 short gap B->A
    tick_div = 2;
    set_cfg(19, 9, 49, 29);
    run_burst(19, 9, 49, 29, 0);                // R10 tick spacing 2
    tick_div = 1;
    set_cfg(119, 59, 7027, 599);
    run_burst(119, 59, 7027, 599, 1);           // R3 default widths 60/600

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule